// File: doc/BRIEF.md
# Interrupt Shadow Register Bank

This block keeps a private copy of seven general registers so that a short interruption handler can use them without saving and restoring them through memory. The seven registers are at indices 1, 8, 9, 16, 17, 24 and 25. When an interruption is taken, the block copies the current values of those seven registers from the register file's read port. A return from interruption that carries the restore option writes the copies back through a wide write-back port in one cycle. After that, the copies are treated as undefined. A return without the option leaves both the copies and the register file as they are.

The block also handles the status side effects of a return:
- It loads the interruption address queues unless both the current and the saved Q-bit are 0.
- It sets the interrupt-enable state from the saved status word, starting in the cycle after the return.
- It flags an attempt to set the Q-bit through a system-mask instruction as an undefined operation.

The controller is a three-state machine:
- `SH_EMPTY`: no valid copy is held.
- `SH_FULL`: a valid copy is held.
- `SH_RESTORE`: a one-cycle state in which the write-back is driven.

Its transitions are:
- Capture: EMPTY or FULL or RESTORE to FULL, when an interruption is taken.
- Restore: FULL to RESTORE, on a restore-return with no interruption in the same cycle.
- Drain: RESTORE to EMPTY, when no interruption arrives.
- All other cases hold the current state.

Top module: `irq_shadow_bank`

## Requirements
- R1: After reset, `shadow_valid_o`, `wb_en_o`, `intr_en_o`, `iiaq_load_o` and `undef_op_o` are 0, and `wb_mask_o` is 0.
- R2: An interruption-taken strobe at a clock edge stores the seven slot values present on `gr_rd_data_i` at that edge. `shadow_valid_o` is 1 from the next cycle.
- R3: Slot k (bits k*DATA_W upward, k = 0..6) of `gr_rd_data_i` and of `wb_data_o` stands for general register 1, 8, 9, 16, 17, 24 or 25, in that order. `wb_mask_o` equals 32'h0303_0302 while `wb_en_o` is 1 and is 0 otherwise.
- R4: A restore-return while the shadows are valid raises `wb_en_o` for exactly one cycle, the cycle after the strobe. In that cycle `wb_data_o` carries the stored values.
- R5: From the cycle after a restore-return, `shadow_valid_o` is 0 until the next interruption. A restore-return while the shadows are invalid produces no write-back.
- R6: A return without the restore option produces no write-back and leaves `shadow_valid_o` and the stored values unchanged.
- R7: When an interruption and a return arrive in the same cycle, the interruption wins and the return is ignored: no write-back and no queue load.
- R8: One cycle after an accepted return, `iiaq_load_o` pulses for one cycle, unless `q_cur_i` and `q_saved_i` were both 0.
- R9: `intr_en_o` takes the value of `saved_ie_i` from the cycle after an accepted return. It is cleared in the cycle after an interruption. It holds otherwise.
- R10: `ssm_set_q_i` raises `undef_op_o` for one cycle, one cycle later.
- R11: An interruption taken during the write-back cycle captures the register values from before that write-back lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| intr_take_i | input | 1 | Interruption taken this cycle |
| rfi_i | input | 1 | Return from interruption this cycle |
| rfi_restore_i | input | 1 | The return carries the restore option |
| q_cur_i | input | 1 | Current status Q-bit |
| q_saved_i | input | 1 | Q-bit of the saved status word |
| saved_ie_i | input | 1 | Interrupt enable of the saved status word |
| ssm_set_q_i | input | 1 | System-mask instruction tries to set Q to 1 |
| gr_rd_data_i | input | 7*DATA_W | Current values of the seven mirrored registers, slot order |
| wb_en_o | output | 1 | Write-back of all seven slots this cycle |
| wb_mask_o | output | GR_COUNT | One-hot-per-register mask of the indices written |
| wb_data_o | output | 7*DATA_W | Stored slot values |
| shadow_valid_o | output | 1 | Stored values are defined |
| intr_en_o | output | 1 | Interrupts enabled |
| iiaq_load_o | output | 1 | Reload the interruption address queues |
| undef_op_o | output | 1 | Undefined-operation flag |

## Verification
Every result is due one clock after its strobe. For a capture, that means `shadow_valid_o`. For a restore-return, it means the write-back pulse and the dropped valid flag. The queue-load pulse, the interrupt-enable value and the undefined-operation pulse also arrive one clock later. The register-file model absorbs the write-back at the following edge.

The bench drives inputs at the falling edge and checks one falling edge later. A monitor compares every write-back pulse against the scoreboard queue at the falling edge inside the pulse. Expected slot values are snapshots taken from the bench's register model at the moment the interruption is driven.

// File: rtl/shd_pkg.sv
package shd_pkg;

    localparam int unsigned SHD_SLOTS = 7;

    typedef enum logic [1:0] {
        SH_EMPTY   = 2'd0,
        SH_FULL    = 2'd1,
        SH_RESTORE = 2'd2
    } shd_state_e;

    // slot 0 -> 1, then pairs 8/9, 16/17, 24/25
    function automatic int unsigned shd_gr_index(input int unsigned slot);
        if (slot == 0) begin
            return 1;
        end
        return 8 * ((slot + 1) / 2) + ((slot + 1) % 2);
    endfunction

endpackage

// File: rtl/shd_bank.sv
module shd_bank #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SLOTS  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_i,
    input  logic [SLOTS*DATA_W-1:0] rd_i,
    output logic [SLOTS*DATA_W-1:0] bank_o
);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (cap_i) begin
                slot_q <= rd_i[k*DATA_W +: DATA_W];
            end
        end
        assign bank_o[k*DATA_W +: DATA_W] = slot_q;
    end

    AST_CAPTURE_TAKES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> bank_o == $past(rd_i)); // R2

endmodule

// File: rtl/shd_ctrl.sv
module shd_ctrl
    import shd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic intr_take_i,
    input  logic rfi_i,
    input  logic rfi_restore_i,
    output logic cap_o,
    output logic wb_en_o,
    output logic valid_o
);

    shd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_EMPTY: begin
                if (intr_take_i) state_d = SH_FULL;
            end
            SH_FULL: begin
                if (intr_take_i) begin
                    state_d = SH_FULL;
                end else if (rfi_i && rfi_restore_i) begin
                    state_d = SH_RESTORE;
                end
            end
            SH_RESTORE: begin
                state_d = intr_take_i ? SH_FULL : SH_EMPTY;
            end
            default: state_d = SH_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cap_o   = intr_take_i;
        valid_o = (state_q == SH_FULL);
        wb_en_o = (state_q == SH_RESTORE);
    end

    AST_RESTORE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && rfi_i && rfi_restore_i && !intr_take_i) |=> wb_en_o); // R4
    AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |=> !wb_en_o); // R4
    AST_INVALID_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en_o && !intr_take_i) |=> !valid_o); // R5
    AST_CAPTURE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        intr_take_i |=> valid_o); // R2

endmodule

// File: rtl/shd_status.sv
module shd_status (
    input  logic clk,
    input  logic rst_n,
    input  logic intr_take_i,
    input  logic rfi_i,
    input  logic q_cur_i,
    input  logic q_saved_i,
    input  logic saved_ie_i,
    input  logic ssm_set_q_i,
    output logic intr_en_o,
    output logic iiaq_load_o,
    output logic undef_op_o
);

    logic rfi_acc;
    assign rfi_acc = rfi_i && !intr_take_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intr_en_o   <= 1'b0;
            iiaq_load_o <= 1'b0;
            undef_op_o  <= 1'b0;
        end else begin
            iiaq_load_o <= rfi_acc && (q_cur_i || q_saved_i);
            undef_op_o  <= ssm_set_q_i;
            if (intr_take_i) begin
                intr_en_o <= 1'b0;
            end else if (rfi_acc) begin
                intr_en_o <= saved_ie_i;
            end
        end
    end

    AST_IIAQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi_i && !q_cur_i && !q_saved_i) |=> !iiaq_load_o); // R8
    AST_UNDEF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ssm_set_q_i |=> undef_op_o); // R10
    AST_INTR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        intr_take_i |=> !intr_en_o && !iiaq_load_o); // R7

endmodule

// File: rtl/irq_shadow_bank.sv
module irq_shadow_bank
    import shd_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned GR_COUNT = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        intr_take_i,
    input  logic                        rfi_i,
    input  logic                        rfi_restore_i,
    input  logic                        q_cur_i,
    input  logic                        q_saved_i,
    input  logic                        saved_ie_i,
    input  logic                        ssm_set_q_i,
    input  logic [SHD_SLOTS*DATA_W-1:0] gr_rd_data_i,
    output logic                        wb_en_o,
    output logic [GR_COUNT-1:0]         wb_mask_o,
    output logic [SHD_SLOTS*DATA_W-1:0] wb_data_o,
    output logic                        shadow_valid_o,
    output logic                        intr_en_o,
    output logic                        iiaq_load_o,
    output logic                        undef_op_o
);

    localparam int unsigned BANK_W = SHD_SLOTS * DATA_W;

    logic              cap;
    logic [BANK_W-1:0] bank;

    shd_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .intr_take_i   (intr_take_i),
        .rfi_i         (rfi_i),
        .rfi_restore_i (rfi_restore_i),
        .cap_o         (cap),
        .wb_en_o       (wb_en_o),
        .valid_o       (shadow_valid_o)
    );

    shd_bank #(
        .DATA_W (DATA_W),
        .SLOTS  (SHD_SLOTS)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .rd_i   (gr_rd_data_i),
        .bank_o (bank)
    );

    shd_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .intr_take_i (intr_take_i),
        .rfi_i       (rfi_i),
        .q_cur_i     (q_cur_i),
        .q_saved_i   (q_saved_i),
        .saved_ie_i  (saved_ie_i),
        .ssm_set_q_i (ssm_set_q_i),
        .intr_en_o   (intr_en_o),
        .iiaq_load_o (iiaq_load_o),
        .undef_op_o  (undef_op_o)
    );

    assign wb_data_o = bank;

    always_comb begin
        wb_mask_o = '0;
        if (wb_en_o) begin
            for (int unsigned k = 0; k < SHD_SLOTS; k++) begin
                wb_mask_o[shd_gr_index(k)] = 1'b1;
            end
        end
    end

    AST_PLAIN_RFI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi_i && !rfi_restore_i && !intr_take_i && !wb_en_o)
        |=> !wb_en_o && $stable(wb_data_o) && $stable(shadow_valid_o)); // R6
    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en_o |-> wb_mask_o == '0); // R3

endmodule

// File: tb/test_irq_shadow_bank.sv
module test_irq_shadow_bank;

    localparam int W = 32;
    localparam int S = 7;
    localparam logic [31:0] MASK = 32'h0303_0302;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic intr = 0, rfi = 0, rst_opt = 0, qc = 0, qs = 0, sie = 0, ssm = 0;
    logic [S*W-1:0] rd;
    logic wb_en, valid, ien, iiaq, undef;
    logic [31:0] mask;
    logic [S*W-1:0] wbd;

    logic [W-1:0] gr [32];
    logic tb_we = 0;
    int   tb_widx = 0;
    logic [W-1:0] tb_wdata = '0;

    int checks = 0;
    int fails = 0;
    logic [S*W-1:0] exp_q [$];
    logic [S*W-1:0] snap, snap2;

    always #5 clk = ~clk;

    function automatic int idx_of(input int k);
        int tbl [S] = '{1, 8, 9, 16, 17, 24, 25};
        return tbl[k];
    endfunction

    irq_shadow_bank i_irq_shadow_bank (
        .clk(clk), .rst_n(rst_n), .intr_take_i(intr), .rfi_i(rfi),
        .rfi_restore_i(rst_opt), .q_cur_i(qc), .q_saved_i(qs),
        .saved_ie_i(sie), .ssm_set_q_i(ssm), .gr_rd_data_i(rd),
        .wb_en_o(wb_en), .wb_mask_o(mask), .wb_data_o(wbd),
        .shadow_valid_o(valid), .intr_en_o(ien), .iiaq_load_o(iiaq),
        .undef_op_o(undef)
    );

    always_comb begin
        for (int k = 0; k < S; k++) rd[k*W +: W] = gr[idx_of(k)];
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) gr[i] <= 32'hA500_0000 + i * 32'h111;
        end else begin
            if (tb_we) gr[tb_widx] <= tb_wdata;
            if (wb_en) begin
                for (int k = 0; k < S; k++) gr[idx_of(k)] <= wbd[k*W +: W];
            end
        end
    end

    task automatic chk(input string req, input logic [S*W-1:0] act, input logic [S*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push_restore(input logic [S*W-1:0] e);
        exp_q.push_back(e);
        rfi = 1; rst_opt = 1;
    endtask

    // monitor: scoreboard compare on every write-back pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (wb_en) begin
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected write-back", 1, 0);
                end else begin
                    chk("R4 R11 wb data", wbd, exp_q.pop_front());
                    chk("R3 wb mask", {192'd0, mask}, {192'd0, MASK});
                end
            end else begin
                chk("R3 idle mask", {192'd0, mask}, '0);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk("R1 valid", valid, 0);
        chk("R1 wb_en", wb_en, 0);
        chk("R1 ien/iiaq/undef", {ien, iiaq, undef}, 0);
        rst_n = 1;
        @(negedge clk);

        // restore-return with no valid shadows
        rfi = 1; rst_opt = 1; qc = 1; qs = 0; sie = 1;
        cyc();
        rfi = 0; rst_opt = 0;
        chk("R5 no wb when invalid", wb_en, 0);
        chk("R8 iiaq load", iiaq, 1);
        chk("R9 ien from saved", ien, 1);
        cyc();
        chk("R8 iiaq one pulse", iiaq, 0);

        // capture
        snap = rd; intr = 1;
        cyc();
        intr = 0;
        chk("R2 valid after capture", valid, 1);
        chk("R9 ien cleared", ien, 0);

        // plain return, both Q zero
        rfi = 1; rst_opt = 0; qc = 0; qs = 0; sie = 0;
        cyc();
        rfi = 0;
        chk("R6 valid kept", valid, 1);
        chk("R6 data kept", wbd, snap);
        chk("R8 queues held", iiaq, 0);
        chk("R6 no wb", wb_en, 0);

        // change a mirrored register after capture
        tb_we = 1; tb_widx = 8; tb_wdata = 32'hDEAD_0008;
        cyc();
        tb_we = 0;

        // restore-return, then interruption inside the write-back cycle
        push_restore(snap); qc = 0; qs = 1; sie = 1;
        cyc();
        rfi = 0; rst_opt = 0;
        chk("R5 valid dropped", valid, 0);
        chk("R8 iiaq", iiaq, 1);
        chk("R9 ien set", ien, 1);
        snap2 = rd; intr = 1;
        cyc();
        intr = 0;
        chk("R11 valid after capture", valid, 1);
        chk("R4 register restored", gr[8], snap[1*W +: W]);
        chk("R11 pre-write value", snap2[1*W +: W], 32'hDEAD_0008);

        // second restore returns the pre-write capture
        push_restore(snap2); qc = 1;
        cyc();
        rfi = 0; rst_opt = 0;
        cyc();
        chk("R4 single pulse", wb_en, 0);
        chk("R11 register now", gr[8], 32'hDEAD_0008);
        for (int i = 0; i < 4; i++) begin
            chk("R5 stays invalid", valid, 0);
            cyc();
        end

        // interruption and return together
        intr = 1;
        cyc();
        snap = rd;
        intr = 1; rfi = 1; rst_opt = 1; sie = 1; qc = 1;
        cyc();
        intr = 0; rfi = 0; rst_opt = 0;
        chk("R7 no wb", wb_en, 0);
        chk("R7 valid", valid, 1);
        chk("R7 ien", ien, 0);
        chk("R7 iiaq", iiaq, 0);
        chk("R7 recaptured", wbd, snap);

        // system-mask set of Q
        ssm = 1;
        cyc();
        ssm = 0;
        chk("R10 undef raised", undef, 1);
        cyc();
        chk("R10 undef pulse", undef, 0);

        chk("R4 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule